// File: doc/BRIEF.md
# SATA PHY Bring-up Sequencer

This block powers up a high-speed serial PHY that several link controllers share, and puts it into SATA mode. A one-cycle start pulse launches one fixed run. The run selects the reference clock path, forces the clock-request overrides so that another link's low-power state cannot stop the shared clock, and cycles the PHY reset. It then sets transmit de-emphasis, pulses the controller reset and releases the PHY configuration-port reset. Once those levels are in place, it polls two status inputs in turn, each with its own retry budget and spacing: first the transmit PLL lock, then the end of PMA calibration.

When both polls pass, the sequencer sends a fixed list of tuning-register writes and two read-backs to the PHY through a byte command port with a valid/ready handshake. A command is offered on `cmd_valid_o` and stays unchanged until the PHY side raises `cmd_ready_i`, so the PHY can stall the list for any number of cycles. Every run ends with a one-cycle `done_o` pulse that carries a 2-bit result code. All microsecond delays come from a clock-cycle prescaler set by a parameter.

Top module: `sata_phy_bringup`

## Requirements
- R1: A start pulse is accepted only when the sequencer is idle. A start that arrives during a run is ignored: it neither restarts nor lengthens the run. Every run ends with exactly one `done_o` pulse, one cycle wide.
- R2: After start, `phy_rst_n_o` is driven low and then released high. Only after that release do `txdeemp_en_o` and `txdeemp_sel_o` both go high.
- R3: With `ext_osc_i`=1 the sequencer drives `rx_ena_o`=1 and `tx_ena_o`=0. With `ext_osc_i`=0 it drives `rx_ena_o`=0 and `tx_ena_o`=1. In both cases it drives `refclk_path_sel_o`=1 and `clkreq_ovr_o`=4'b1111.
- R4: `ctrl_rst_n_o` (low at start) is released, held high for at least CTRL_RST_US microseconds, driven low for one cycle, and released again. It has exactly two rising edges per run.
- R5: After `phy_cfg_rst_n_o` is released, `pll_lock_i` is checked up to PLL_TRIES times, PLL_GAP_US microseconds apart. If no check sees lock, the run ends with status 2'd1 and no command is issued.
- R6: After lock, `pma_rdy_i` is checked up to PMA_TRIES times, PMA_GAP_US microseconds apart. If no check sees it high, the run ends with status 2'd2 and no command is issued.
- R7: On success the commands come in this order: write the impedance to 0x03, write it to 0x09, read 0x03, read 0x09, then write 0x64 to 0x18, 0x70 to 0x19, 0x69 to 0x1a, 0x15 to 0x0a, 0x00 to 0x16, and finally 0x01 to 0x80. The run then ends with status 2'd0. `cmd_write_o`=1 marks a write. The impedance is the value of `imped_i` captured at start.
- R8: `warn_o` is cleared at start. It is set when read-back data differs from the captured impedance. A mismatch does not change the status code.
- R9: While `cmd_valid_o` is high and `cmd_ready_i` is low, the next cycle keeps `cmd_valid_o` high with the same address, data and write flag. A command completes on a cycle where both are high. For a read, `rd_data_i` is sampled in that same cycle.
- R10: No command is offered until `phy_rst_n_o`, `ctrl_rst_n_o` and `phy_cfg_rst_n_o` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, used only when idle |
| ext_osc_i | input | 1 | 1 selects the external oscillator, 0 the internal PLL |
| pll_lock_i | input | 1 | Transmit PLL lock status |
| pma_rdy_i | input | 1 | PMA calibration finished |
| imped_i | input | 8 | Impedance ratio, captured at start |
| phy_rst_n_o | output | 1 | PHY reset, active low |
| txdeemp_en_o | output | 1 | Transmit de-emphasis enable |
| txdeemp_sel_o | output | 1 | Transmit de-emphasis select |
| ctrl_rst_n_o | output | 1 | Controller reset, active low |
| phy_cfg_rst_n_o | output | 1 | PHY configuration-port reset, active low |
| rx_ena_o | output | 1 | Reference clock receiver enable |
| tx_ena_o | output | 1 | Reference clock driver enable |
| refclk_path_sel_o | output | 1 | Reference clock path select for the SATA lane |
| clkreq_ovr_o | output | 4 | Clock-request override bits |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | PHY accepts the command |
| cmd_write_o | output | 1 | 1 = write, 0 = read |
| cmd_addr_o | output | 8 | PHY register address |
| cmd_wdata_o | output | 8 | Write data (0 for reads) |
| rd_data_i | input | 8 | Read data, valid in the handshake cycle of a read |
| done_o | output | 1 | One-cycle end-of-run pulse |
| status_o | output | 2 | 0 ok, 1 no PLL lock, 2 calibration not finished |
| warn_o | output | 1 | Read-back mismatch seen in this run |

## Verification
The assertions check on every cycle the rules that hold at any instant. These are the stability of a stalled command, no command while any reset is held, a consistent clock-source setting with all overrides forced, de-emphasis only while the PHY reset is released, and a one-cycle done pulse with a legal code. Only the bench scenarios can show the properties that span a whole run. These are the exact order and contents of the command list, the length of the controller-reset high phase, and the poll budgets that lead to each failure code. The same applies to the read-back warning, and to a mid-run start leaving the run length unchanged.

// File: rtl/sata_bringup_pkg.sv
package sata_bringup_pkg;

  localparam int CMD_ADDR_W = 8;
  localparam int CMD_DATA_W = 8;
  localparam int NUM_CMDS   = 10;
  localparam int IDX_W      = $clog2(NUM_CMDS);

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_NO_PLL = 2'd1,
    RES_NO_CAL = 2'd2
  } result_e;

  typedef struct packed {
    logic                  write;
    logic [CMD_ADDR_W-1:0] addr;
    logic [CMD_DATA_W-1:0] data;
  } cmd_t;

  // Fixed tuning list; entries 2 and 3 read back the impedance registers.
  function automatic cmd_t cmd_at(input logic [IDX_W-1:0] idx,
                                  input logic [CMD_DATA_W-1:0] imp);
    cmd_t c;
    c = '{write: 1'b1, addr: '0, data: '0};
    case (idx)
      IDX_W'(0): begin c.addr = 8'h03; c.data = imp; end
      IDX_W'(1): begin c.addr = 8'h09; c.data = imp; end
      IDX_W'(2): begin c.write = 1'b0; c.addr = 8'h03; end
      IDX_W'(3): begin c.write = 1'b0; c.addr = 8'h09; end
      IDX_W'(4): begin c.addr = 8'h18; c.data = 8'h64; end
      IDX_W'(5): begin c.addr = 8'h19; c.data = 8'h70; end
      IDX_W'(6): begin c.addr = 8'h1a; c.data = 8'h69; end
      IDX_W'(7): begin c.addr = 8'h0a; c.data = 8'h15; end
      IDX_W'(8): begin c.addr = 8'h16; c.data = 8'h00; end
      default:   begin c.addr = 8'h80; c.data = 8'h01; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sata_bringup_us_timer.sv
module sata_bringup_us_timer #(
  parameter int CLKS_PER_US = 125,
  parameter int US_W        = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [US_W-1:0] len_i,
  output logic            expired_o
);

  localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [US_W-1:0]  left_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      left_q    <= '0;
      run_q     <= 1'b0;
      expired_o <= 1'b0;
    end else begin
      expired_o <= 1'b0;
      if (start_i) begin
        pre_q  <= '0;
        left_q <= len_i;
        run_q  <= 1'b1;
      end else if (run_q) begin
        if (pre_q == PRE_W'(CLKS_PER_US - 1)) begin
          pre_q <= '0;
          if (left_q <= US_W'(1)) begin
            run_q     <= 1'b0;
            expired_o <= 1'b1;
          end else begin
            left_q <= left_q - US_W'(1);
          end
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sata_bringup_retry.sv
module sata_bringup_retry #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + CW'(1);
  end

  assign last_o = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/sata_phy_bringup.sv
module sata_phy_bringup
  import sata_bringup_pkg::*;
#(
  parameter int CLKS_PER_US = 125,
  parameter int CTRL_RST_US = 1,
  parameter int PLL_TRIES   = 100,
  parameter int PLL_GAP_US  = 1,
  parameter int PMA_TRIES   = 1000,
  parameter int PMA_GAP_US  = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  ext_osc_i,
  input  logic                  pll_lock_i,
  input  logic                  pma_rdy_i,
  input  logic [CMD_DATA_W-1:0] imped_i,
  output logic                  phy_rst_n_o,
  output logic                  txdeemp_en_o,
  output logic                  txdeemp_sel_o,
  output logic                  ctrl_rst_n_o,
  output logic                  phy_cfg_rst_n_o,
  output logic                  rx_ena_o,
  output logic                  tx_ena_o,
  output logic                  refclk_path_sel_o,
  output logic [3:0]            clkreq_ovr_o,
  output logic                  cmd_valid_o,
  input  logic                  cmd_ready_i,
  output logic                  cmd_write_o,
  output logic [CMD_ADDR_W-1:0] cmd_addr_o,
  output logic [CMD_DATA_W-1:0] cmd_wdata_o,
  input  logic [CMD_DATA_W-1:0] rd_data_i,
  output logic                  done_o,
  output logic [1:0]            status_o,
  output logic                  warn_o
);

  localparam int MAX_A  = (CTRL_RST_US > PLL_GAP_US) ? CTRL_RST_US : PLL_GAP_US;
  localparam int MAX_US = (MAX_A > PMA_GAP_US) ? MAX_A : PMA_GAP_US;
  localparam int US_W   = $clog2(MAX_US + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CFG, S_PHY_REL, S_DEEMP, S_CRST_REL, S_CRST_WAIT,
    S_CRST_ASSERT, S_CRST_REL2, S_CFG_REL, S_PLL_CHK, S_PLL_WAIT,
    S_PMA_CHK, S_PMA_WAIT, S_CMD, S_DONE
  } state_e;

  state_e                state_q;
  logic [IDX_W-1:0]      idx_q;
  logic [CMD_DATA_W-1:0] imp_q;
  logic [1:0]            status_q;
  cmd_t                  cur_cmd;

  logic            tmr_start, tmr_expired;
  logic [US_W-1:0] tmr_len;
  logic            pll_last, pma_last;
  logic            pll_fail_chk, pma_fail_chk, cmd_fire;

  assign pll_fail_chk = (state_q == S_PLL_CHK) && !pll_lock_i;
  assign pma_fail_chk = (state_q == S_PMA_CHK) && !pma_rdy_i;
  assign cur_cmd      = cmd_at(idx_q, imp_q);
  assign cmd_valid_o  = (state_q == S_CMD);
  assign cmd_write_o  = cmd_valid_o & cur_cmd.write;
  assign cmd_addr_o   = cmd_valid_o ? cur_cmd.addr : '0;
  assign cmd_wdata_o  = cmd_valid_o ? cur_cmd.data : '0;
  assign cmd_fire     = cmd_valid_o && cmd_ready_i;
  assign done_o       = (state_q == S_DONE);
  assign status_o     = status_q;

  always_comb begin
    tmr_start = 1'b0;
    tmr_len   = US_W'(CTRL_RST_US);
    if (state_q == S_CRST_REL) begin
      tmr_start = 1'b1;
    end else if (pll_fail_chk && !pll_last) begin
      tmr_start = 1'b1;
      tmr_len   = US_W'(PLL_GAP_US);
    end else if (pma_fail_chk && !pma_last) begin
      tmr_start = 1'b1;
      tmr_len   = US_W'(PMA_GAP_US);
    end
  end

  sata_bringup_us_timer #(.CLKS_PER_US(CLKS_PER_US), .US_W(US_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .start_i(tmr_start), .len_i(tmr_len),
    .expired_o(tmr_expired)
  );

  sata_bringup_retry #(.LIMIT(PLL_TRIES)) i_pll_retry (
    .clk(clk), .rst_n(rst_n), .clr_i(state_q == S_CFG_REL),
    .inc_i(pll_fail_chk && !pll_last), .last_o(pll_last)
  );

  sata_bringup_retry #(.LIMIT(PMA_TRIES)) i_pma_retry (
    .clk(clk), .rst_n(rst_n), .clr_i((state_q == S_PLL_CHK) && pll_lock_i),
    .inc_i(pma_fail_chk && !pma_last), .last_o(pma_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q           <= S_IDLE;
      idx_q             <= '0;
      imp_q             <= '0;
      status_q          <= RES_OK;
      warn_o            <= 1'b0;
      phy_rst_n_o       <= 1'b0;
      txdeemp_en_o      <= 1'b0;
      txdeemp_sel_o     <= 1'b0;
      ctrl_rst_n_o      <= 1'b0;
      phy_cfg_rst_n_o   <= 1'b0;
      rx_ena_o          <= 1'b0;
      tx_ena_o          <= 1'b0;
      refclk_path_sel_o <= 1'b0;
      clkreq_ovr_o      <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          phy_rst_n_o     <= 1'b0;
          ctrl_rst_n_o    <= 1'b0;
          phy_cfg_rst_n_o <= 1'b0;
          txdeemp_en_o    <= 1'b0;
          txdeemp_sel_o   <= 1'b0;
          warn_o          <= 1'b0;
          imp_q           <= imped_i;
          state_q         <= S_CFG;
        end
        S_CFG: begin
          rx_ena_o          <= ext_osc_i;
          tx_ena_o          <= !ext_osc_i;
          refclk_path_sel_o <= 1'b1;
          clkreq_ovr_o      <= '1;
          state_q           <= S_PHY_REL;
        end
        S_PHY_REL: begin
          phy_rst_n_o <= 1'b1;
          state_q     <= S_DEEMP;
        end
        S_DEEMP: begin
          txdeemp_en_o  <= 1'b1;
          txdeemp_sel_o <= 1'b1;
          state_q       <= S_CRST_REL;
        end
        S_CRST_REL: begin
          ctrl_rst_n_o <= 1'b1;
          state_q      <= S_CRST_WAIT;
        end
        S_CRST_WAIT: if (tmr_expired) state_q <= S_CRST_ASSERT;
        S_CRST_ASSERT: begin
          ctrl_rst_n_o <= 1'b0;
          state_q      <= S_CRST_REL2;
        end
        S_CRST_REL2: begin
          ctrl_rst_n_o <= 1'b1;
          state_q      <= S_CFG_REL;
        end
        S_CFG_REL: begin
          phy_cfg_rst_n_o <= 1'b1;
          state_q         <= S_PLL_CHK;
        end
        S_PLL_CHK: begin
          if (pll_lock_i)    state_q <= S_PMA_CHK;
          else if (pll_last) begin
            status_q <= RES_NO_PLL;
            state_q  <= S_DONE;
          end else           state_q <= S_PLL_WAIT;
        end
        S_PLL_WAIT: if (tmr_expired) state_q <= S_PLL_CHK;
        S_PMA_CHK: begin
          if (pma_rdy_i) begin
            idx_q   <= '0;
            state_q <= S_CMD;
          end else if (pma_last) begin
            status_q <= RES_NO_CAL;
            state_q  <= S_DONE;
          end else state_q <= S_PMA_WAIT;
        end
        S_PMA_WAIT: if (tmr_expired) state_q <= S_PMA_CHK;
        S_CMD: if (cmd_fire) begin
          if (!cur_cmd.write && (rd_data_i != imp_q)) warn_o <= 1'b1;
          if (idx_q == IDX_W'(NUM_CMDS - 1)) begin
            status_q <= RES_OK;
            state_q  <= S_DONE;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sata_phy_bringup_chk.sv
module sata_phy_bringup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phy_rst_n_o,
  input logic       txdeemp_en_o,
  input logic       ctrl_rst_n_o,
  input logic       phy_cfg_rst_n_o,
  input logic       rx_ena_o,
  input logic       tx_ena_o,
  input logic       refclk_path_sel_o,
  input logic [3:0] clkreq_ovr_o,
  input logic       cmd_valid_o,
  input logic       cmd_ready_i,
  input logic       cmd_write_o,
  input logic [7:0] cmd_addr_o,
  input logic [7:0] cmd_wdata_o,
  input logic       done_o,
  input logic [1:0] status_o
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R1

  AST_DONE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cmd_valid_o); // R1

  AST_DEEMP_AFTER_PHY_REL: assert property (@(posedge clk) disable iff (!rst_n)
    txdeemp_en_o |-> phy_rst_n_o); // R2

  AST_CLK_SRC_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
    refclk_path_sel_o |-> ((rx_ena_o ^ tx_ena_o) && (clkreq_ovr_o == 4'hF))); // R3

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (status_o != 2'd3)); // R5

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_addr_o)
      && $stable(cmd_wdata_o) && $stable(cmd_write_o))); // R9

  AST_NO_EARLY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (phy_rst_n_o && ctrl_rst_n_o && phy_cfg_rst_n_o)); // R10

endmodule

bind sata_phy_bringup sata_phy_bringup_chk i_chk (.*);

// File: tb/test_sata_phy_bringup.sv
module test_sata_phy_bringup;

  localparam int CLKS  = 4;
  localparam int CRST  = 2;
  localparam int PLL_N = 5;
  localparam int PLL_G = 2;
  localparam int PMA_N = 6;
  localparam int PMA_G = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, ext_osc = 1'b1, pll_lock = 1'b0, pma_rdy = 1'b0;
  logic [7:0] imped = 8'h6c;
  logic       cmd_ready = 1'b0, corrupt = 1'b0;
  logic [7:0] rd_data;
  logic       phy_rst_n, deemp_en, deemp_sel, ctrl_rst_n, cfg_rst_n;
  logic       rx_ena, tx_ena, path_sel, cmd_valid, cmd_write, done, warn;
  logic [3:0] clkreq;
  logic [7:0] cmd_addr, cmd_wdata;
  logic [1:0] status;

  assign rd_data = corrupt ? (imped ^ 8'h01) : imped;

  always #4 clk = ~clk;

  sata_phy_bringup #(.CLKS_PER_US(CLKS), .CTRL_RST_US(CRST), .PLL_TRIES(PLL_N),
    .PLL_GAP_US(PLL_G), .PMA_TRIES(PMA_N), .PMA_GAP_US(PMA_G)) i_sata_phy_bringup (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ext_osc_i(ext_osc),
    .pll_lock_i(pll_lock), .pma_rdy_i(pma_rdy), .imped_i(imped),
    .phy_rst_n_o(phy_rst_n), .txdeemp_en_o(deemp_en), .txdeemp_sel_o(deemp_sel),
    .ctrl_rst_n_o(ctrl_rst_n), .phy_cfg_rst_n_o(cfg_rst_n), .rx_ena_o(rx_ena),
    .tx_ena_o(tx_ena), .refclk_path_sel_o(path_sel), .clkreq_ovr_o(clkreq),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_write_o(cmd_write),
    .cmd_addr_o(cmd_addr), .cmd_wdata_o(cmd_wdata), .rd_data_i(rd_data),
    .done_o(done), .status_o(status), .warn_o(warn)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, t0 = 0, rdy_cnt = 0;
  int pll_at = -1, pma_at = -1, extra_at = -1;
  bit run_on = 0, stall = 0, phy_lo_seen = 0;
  int ctrl_rises = 0, ctrl_first_rise = -1, ctrl_last_fall = -1;
  int phy_rise_t = -1, deemp_rise_t = -1, done_cnt = 0;
  logic prev_ctrl = 1'b0, prev_phy = 1'b0, prev_deemp = 1'b0;
  logic [16:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Driver side of the stimulus and the scoreboard monitor, all at negedge.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
        finish_run();
      end
      rdy_cnt++;
      cmd_ready = stall ? ((rdy_cnt % 3) != 1) : 1'b1;
      if (run_on) begin
        if (pll_at >= 0 && (cyc - t0) >= pll_at) pll_lock = 1'b1;
        if (pma_at >= 0 && (cyc - t0) >= pma_at) pma_rdy = 1'b1;
        if (extra_at > 0) start = ((cyc - t0) == extra_at);
        if (!phy_rst_n) phy_lo_seen = 1;
        if (phy_rst_n && !prev_phy) phy_rise_t = cyc;
        if (deemp_en && !prev_deemp) deemp_rise_t = cyc;
        if (ctrl_rst_n && !prev_ctrl) begin
          ctrl_rises++;
          if (ctrl_first_rise < 0) ctrl_first_rise = cyc;
        end
        if (!ctrl_rst_n && prev_ctrl) ctrl_last_fall = cyc;
      end
      prev_ctrl = ctrl_rst_n; prev_phy = phy_rst_n; prev_deemp = deemp_en;
      if (done) done_cnt++;
      if (rst_n && cmd_valid && cmd_ready) begin
        check(phy_rst_n && ctrl_rst_n && cfg_rst_n, "R10", "resets at cmd",
              {phy_rst_n, ctrl_rst_n, cfg_rst_n}, 7);
        if (exp_q.size() == 0) begin
          check(0, "R7", "unexpected cmd addr", cmd_addr, 0);
        end else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          check(cmd_write == e[16] && cmd_addr == e[15:8] &&
                (!e[16] || cmd_wdata == e[7:0]), "R7", "cmd {w,addr,data}",
                {cmd_write, cmd_addr, cmd_wdata}, e);
        end
      end
    end
  end

  task automatic push(input bit w, input logic [7:0] a, input logic [7:0] d);
    exp_q.push_back({w, a, d});
  endtask

  task automatic run_case(input string name, input bit ext, input logic [7:0] imp,
                          input bit bad_rd, input int p_at, input int m_at,
                          input bit stl, input int x_at, input int exp_st,
                          output int dur);
    int waited;
    @(negedge clk);
    ext_osc = ext; imped = imp; corrupt = bad_rd; stall = stl;
    pll_lock = 1'b0; pma_rdy = 1'b0;
    pll_at = p_at; pma_at = m_at; extra_at = x_at;
    phy_lo_seen = 0; ctrl_rises = 0; ctrl_first_rise = -1; ctrl_last_fall = -1;
    phy_rise_t = -1; deemp_rise_t = -1; done_cnt = 0;
    exp_q.delete();
    if (exp_st == 0) begin
      push(1, 8'h03, imp); push(1, 8'h09, imp);
      push(0, 8'h03, 8'h00); push(0, 8'h09, 8'h00);
      push(1, 8'h18, 8'h64); push(1, 8'h19, 8'h70); push(1, 8'h1a, 8'h69);
      push(1, 8'h0a, 8'h15); push(1, 8'h16, 8'h00); push(1, 8'h80, 8'h01);
    end
    start = 1'b1; t0 = cyc; rdy_cnt = 0; run_on = 1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    dur = cyc - t0;
    $display("run %s: %0d cycles", name, dur);
    check(done, "R1", "done reached", done, 1);
    check(status == exp_st[1:0], (exp_st == 1) ? "R5" : (exp_st == 2) ? "R6" : "R7",
          "status", status, exp_st);
    check(exp_q.size() == 0, "R7", "unsent expected cmds", exp_q.size(), 0);
    check(warn == bad_rd, "R8", "warn", warn, bad_rd);
    check(rx_ena == ext && tx_ena == !ext && path_sel && clkreq == 4'hF, "R3",
          "{rx,tx,sel,ovr}", {rx_ena, tx_ena, path_sel, clkreq}, {ext, !ext, 1'b1, 4'hF});
    check(phy_lo_seen && phy_rst_n && deemp_en && deemp_sel && deemp_rise_t > phy_rise_t,
          "R2", "phy rel before deemp", deemp_rise_t, phy_rise_t + 1);
    check(ctrl_rises == 2 && ctrl_rst_n, "R4", "ctrl reset rises", ctrl_rises, 2);
    check(ctrl_last_fall - ctrl_first_rise >= CRST * CLKS, "R4", "ctrl high width",
          ctrl_last_fall - ctrl_first_rise, CRST * CLKS);
    if (exp_st == 1)
      check(dur >= (PLL_N - 1) * PLL_G * CLKS, "R5", "pll poll span", dur,
            (PLL_N - 1) * PLL_G * CLKS);
    if (exp_st == 2)
      check(dur >= (PMA_N - 1) * PMA_G * CLKS, "R6", "pma poll span", dur,
            (PMA_N - 1) * PMA_G * CLKS);
    repeat (30) @(negedge clk);
    check(done_cnt == 1, "R1", "done pulses", done_cnt, 1);
    run_on = 0; extra_at = -1; start = 1'b0;
  endtask

  initial begin
    int d_a, d_b, d_tmp;
    repeat (3) @(negedge clk);
    check(!phy_rst_n && !ctrl_rst_n && !cfg_rst_n && !cmd_valid && !done && !warn,
          "R1", "reset levels", {phy_rst_n, ctrl_rst_n, cfg_rst_n, cmd_valid, done, warn}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && !cmd_valid && !path_sel, "R1", "idle after reset",
          {done, cmd_valid, path_sel}, 0);

    run_case("ext_ok",    1'b1, 8'h6c, 1'b0, 10, 30, 1'b0, -1, 0, d_a);
    run_case("int_warn",  1'b0, 8'h80, 1'b1, 12, 60, 1'b1, -1, 0, d_tmp);
    run_case("ext_again", 1'b1, 8'h6c, 1'b0, 10, 30, 1'b0, 40, 0, d_b);
    check(d_b == d_a, "R1", "mid-run start changed length", d_b, d_a);
    run_case("no_pll",    1'b1, 8'h6c, 1'b0, -1, -1, 1'b0, -1, 1, d_tmp);
    run_case("no_cal",    1'b0, 8'h6c, 1'b0, 15, -1, 1'b0, -1, 2, d_tmp);
    run_case("recover",   1'b1, 8'h55, 1'b0, 0, 0, 1'b1, -1, 0, d_tmp);
    finish_run();
  end

endmodule